// File: doc/BRIEF.md
# Dual 16-bit multiply-accumulate unit

Two multiply-accumulate lanes run side by side. Each lane picks a 16-bit half (upper or lower) of each of two shared 32-bit source words, multiplies the two halves and then does one of four things with its own 40-bit accumulator. It can replace the accumulator with the product, add the product, subtract the product, or keep the accumulator and only read it out. Each lane can also write a 32-bit result. That result is the new accumulator value, scaled and saturated for the destination. When a lane does not write, only its accumulator changes.

One shared 3-bit format field applies to both lanes in a transfer. It selects the operand interpretation: signed fraction, unsigned fraction, signed integer, or signed-by-unsigned on lane 1. It also selects whether the value is doubled on the way out. Transfers enter over a valid/ready handshake, and results leave over a second one. A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its results appear on the outputs after that edge and stay unchanged while `out_valid` is high and `out_ready` is low. During that time `in_ready` is low, and no accumulator changes.

Top module: `dual_mac`

## Requirements
- R1: After reset both accumulators hold 0, `out_valid` is 0 and `in_ready` is 1.
- R2: The lane operation codes are 0 load, 1 add and 2 subtract. Each sets the accumulator to the product, to accumulator plus product, or to accumulator minus product. The product is sign-extended to 40 bits, and the accumulator wraps modulo 2^40.
- R3: Operation code 3 (hold) leaves the accumulator unchanged, and the written result is derived from the current accumulator.
- R4: Format 0, and the unused codes 6 and 7, multiply two signed 16-bit values and double the product. The product of 0x8000 by 0x8000 is replaced by 0x7FFFFFFF.
- R5: Format 1 multiplies two unsigned 16-bit values and doubles the product, with no substitution. On extraction, any accumulator with a bit set above bit 31 gives 0xFFFFFFFF. Otherwise the result is the low 32 bits.
- R6: Format 2 multiplies two signed 16-bit integers and does not double the product.
- R7: In format 3, lane 1 multiplies a signed first operand by an unsigned second operand, doubled, with no substitution. Lane 0 behaves as in format 0.
- R8: Format 4 computes products as in format 0. The accumulator value is doubled on extraction and then saturated to the signed 32-bit range.
- R9: Format 5 computes products as in format 2. The accumulator value is doubled on extraction and then saturated to the signed 32-bit range.
- R10: In all formats except 1, extraction saturates the 40-bit signed value to the range 0x80000000..0x7FFFFFFF.
- R11: Lane selection bits are {a_hi, b_hi}. A set bit takes bits 31:16 of the source word, and a clear bit takes bits 15:0. Lane 0 and lane 1 select independently.
- R12: `res_wr[n]` equals the lane-n write request of the accepted transfer. `resN` is 0 when its lane does not write. The accumulator of a lane that does not write still updates.
- R13: While `out_valid` is 1 and `out_ready` is 0, the outputs stay unchanged, `in_ready` is 0 and no accumulator changes. Raising `out_ready` lets exactly one waiting transfer through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transfer offered |
| in_ready | output | 1 | Transfer can be accepted |
| fmt | input | 3 | Shared operand and extraction format |
| op0 | input | 2 | Lane 0 accumulator operation |
| op1 | input | 2 | Lane 1 accumulator operation |
| sel0 | input | 2 | Lane 0 half selection {a_hi, b_hi} |
| sel1 | input | 2 | Lane 1 half selection {a_hi, b_hi} |
| wr0 | input | 1 | Lane 0 writes a result |
| wr1 | input | 1 | Lane 1 writes a result |
| src_a | input | 32 | First operand word |
| src_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| res0 | output | 32 | Lane 0 extracted result |
| res1 | output | 32 | Lane 1 extracted result |
| res_wr | output | 2 | Per-lane written flags, bit n for lane n |

## Verification
A corrupted accumulator is not visible at the moment it goes wrong. It shows up on the next written result of that lane. With the write enabled this is the cycle after the faulty transfer. With the write disabled it can be many transfers later, so the bench follows every silent update with a hold-and-write readout. Extraction faults, such as a wrong saturation bound, a missing doubling or a wrong unsigned clip, appear on the very next result. The vectors therefore walk each accumulator across the 32-bit limits, and one run drives it past the 40-bit wrap point. A fault in the stall logic shows as a result that changes while held, or as an extra accumulation once the stall is released.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_HOLD = 2'd3
  } acc_op_e;

  localparam logic [2:0] FMT_SFRAC = 3'd0;
  localparam logic [2:0] FMT_UFRAC = 3'd1;
  localparam logic [2:0] FMT_SINT  = 3'd2;
  localparam logic [2:0] FMT_MIXED = 3'd3;
  localparam logic [2:0] FMT_SF_X2 = 3'd4;
  localparam logic [2:0] FMT_SI_X2 = 3'd5;

  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic frac;
    logic sat_min;
    logic out_x2;
    logic out_uns;
  } lane_fmt_t;

  function automatic lane_fmt_t decode_fmt(input logic [2:0] code, input logic mixed_lane);
    lane_fmt_t f;
    f = '{a_sgn: 1'b1, b_sgn: 1'b1, frac: 1'b1, sat_min: 1'b1, out_x2: 1'b0, out_uns: 1'b0};
    case (code)
      FMT_UFRAC: f = '{a_sgn: 1'b0, b_sgn: 1'b0, frac: 1'b1, sat_min: 1'b0, out_x2: 1'b0, out_uns: 1'b1};
      FMT_SINT:  f = '{a_sgn: 1'b1, b_sgn: 1'b1, frac: 1'b0, sat_min: 1'b0, out_x2: 1'b0, out_uns: 1'b0};
      FMT_MIXED: if (mixed_lane)
                   f = '{a_sgn: 1'b1, b_sgn: 1'b0, frac: 1'b1, sat_min: 1'b0, out_x2: 1'b0, out_uns: 1'b0};
      FMT_SF_X2: f.out_x2 = 1'b1;
      FMT_SI_X2: f = '{a_sgn: 1'b1, b_sgn: 1'b1, frac: 1'b0, sat_min: 1'b0, out_x2: 1'b1, out_uns: 1'b0};
      default: ;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/dmac_mult.sv
module dmac_mult
  import dmac_pkg::*;
#(
  parameter int OPW  = 16,
  parameter int ACCW = 40
) (
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  input  lane_fmt_t       f,
  output logic [ACCW-1:0] prod
);
  localparam int RAWW = 2 * OPW + 2;
  localparam int SHW  = RAWW + 1;
  localparam logic [OPW-1:0]  MINV = {1'b1, {(OPW-1){1'b0}}};
  localparam logic [ACCW-1:0] MAXP = {{(ACCW-2*OPW+1){1'b0}}, {(2*OPW-1){1'b1}}};

  logic signed [OPW:0]    ea, eb;
  logic signed [RAWW-1:0] raw;
  logic        [SHW-1:0]  shf;
  logic                   min_case;

  always_comb begin
    ea  = {f.a_sgn & opa[OPW-1], opa};
    eb  = {f.b_sgn & opb[OPW-1], opb};
    raw = ea * eb;
    shf = f.frac ? {raw, 1'b0} : {raw[RAWW-1], raw};
    min_case = f.sat_min && (opa == MINV) && (opb == MINV);
    prod = min_case ? MAXP : {{(ACCW-SHW){shf[SHW-1]}}, shf};
  end

endmodule

// File: rtl/dmac_extract.sv
module dmac_extract #(
  parameter int ACCW = 40,
  parameter int RESW = 32
) (
  input  logic [ACCW-1:0] acc_val,
  input  logic            x2,
  input  logic            uns,
  output logic [RESW-1:0] res
);
  localparam logic [RESW-1:0] SMAX = {1'b0, {(RESW-1){1'b1}}};
  localparam logic [RESW-1:0] SMIN = {1'b1, {(RESW-1){1'b0}}};

  logic [ACCW:0]      wide;
  logic [ACCW-RESW+1:0] top;

  always_comb begin
    wide = x2 ? {acc_val, 1'b0} : {acc_val[ACCW-1], acc_val};
    top  = wide[ACCW:RESW-1];
    if (uns) begin
      res = (|acc_val[ACCW-1:RESW]) ? {RESW{1'b1}} : acc_val[RESW-1:0];
    end else if ((&top) || !(|top)) begin
      res = wide[RESW-1:0];
    end else begin
      res = wide[ACCW] ? SMIN : SMAX;
    end
  end

endmodule

// File: rtl/dmac_lane.sv
module dmac_lane
  import dmac_pkg::*;
#(
  parameter int LANE = 0,
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int RESW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [2:0]        fmt,
  input  logic [1:0]        op,
  input  logic [1:0]        sel,
  input  logic [2*OPW-1:0]  src_a,
  input  logic [2*OPW-1:0]  src_b,
  output logic [RESW-1:0]   res_nx
);
  localparam logic MIXED_LANE = (LANE == 1);

  lane_fmt_t       f;
  logic [OPW-1:0]  ha, hb;
  logic [ACCW-1:0] prod;
  logic [ACCW-1:0] acc, acc_nx;

  always_comb begin
    f  = decode_fmt(fmt, MIXED_LANE);
    ha = sel[1] ? src_a[2*OPW-1:OPW] : src_a[OPW-1:0];
    hb = sel[0] ? src_b[2*OPW-1:OPW] : src_b[OPW-1:0];
  end

  dmac_mult #(.OPW(OPW), .ACCW(ACCW)) u_mult (
    .opa (ha),
    .opb (hb),
    .f   (f),
    .prod(prod)
  );

  always_comb begin
    case (acc_op_e'(op))
      OP_LOAD: acc_nx = prod;
      OP_ADD:  acc_nx = acc + prod;
      OP_SUB:  acc_nx = acc - prod;
      default: acc_nx = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (fire) acc <= acc_nx;
  end

  dmac_extract #(.ACCW(ACCW), .RESW(RESW)) u_ext (
    .acc_val(acc_nx),
    .x2     (f.out_x2),
    .uns    (f.out_uns),
    .res    (res_nx)
  );

  p_idle_keeps_acc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(acc));

  p_hold_keeps_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_HOLD) |=> $stable(acc));

  p_load_takes_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_LOAD) |=> acc == $past(prod));

  p_unsigned_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fmt == FMT_UFRAC) |-> !prod[ACCW-1]);

endmodule

// File: rtl/dual_mac.sv
module dual_mac #(
  parameter int OPW  = 16,
  parameter int ACCW = 40,
  parameter int RESW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        fmt,
  input  logic [1:0]        op0,
  input  logic [1:0]        op1,
  input  logic [1:0]        sel0,
  input  logic [1:0]        sel1,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [2*OPW-1:0]  src_a,
  input  logic [2*OPW-1:0]  src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RESW-1:0]   res0,
  output logic [RESW-1:0]   res1,
  output logic [1:0]        res_wr
);
  localparam int LANES = 2;

  logic            fire;
  logic [1:0]      op_v  [LANES];
  logic [1:0]      sel_v [LANES];
  logic [LANES-1:0] wr_v;
  logic [RESW-1:0] nx_v  [LANES];
  logic [RESW-1:0] res_q [LANES];

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  assign op_v[0]  = op0;
  assign op_v[1]  = op1;
  assign sel_v[0] = sel0;
  assign sel_v[1] = sel1;
  assign wr_v     = {wr1, wr0};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmac_lane #(.LANE(g), .OPW(OPW), .ACCW(ACCW), .RESW(RESW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .fmt   (fmt),
      .op    (op_v[g]),
      .sel   (sel_v[g]),
      .src_a (src_a),
      .src_b (src_b),
      .res_nx(nx_v[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)    res_q[g] <= '0;
      else if (fire) res_q[g] <= wr_v[g] ? nx_v[g] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_wr    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      res_wr    <= wr_v;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign res0 = res_q[0];
  assign res1 = res_q[1];

  p_stall_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res0) && $stable(res1) && $stable(res_wr)));

  p_unwritten_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr0) |=> (res0 == '0));

endmodule

// File: tb/sim_dual_mac.sv
module sim_dual_mac;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [2:0] fmt = '0;
  logic [1:0] op0 = '0, op1 = '0, sel0 = '0, sel1 = '0, res_wr;
  logic wr0 = 1'b0, wr1 = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, res0, res1;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dual_mac u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .fmt(fmt), .op0(op0), .op1(op1), .sel0(sel0), .sel1(sel1),
    .wr0(wr0), .wr1(wr1), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .res0(res0), .res1(res1), .res_wr(res_wr)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic [1:0]  o0, o1, s0, s1, wr;
    logic [31:0] a, b, e0, e1;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h40002000, 32'h40004000, 32'h10000000, 32'h20000000, 4'd2},  // R2 load
    '{3'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h40002000, 32'h40004000, 32'h20000000, 32'h40000000, 4'd2},  // R2 add
    '{3'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h40002000, 32'h40004000, 32'h30000000, 32'h60000000, 4'd2},  // R2
    '{3'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h40002000, 32'h40004000, 32'h40000000, 32'h7FFFFFFF, 4'd10}, // R10 max
    '{3'd0, 2'd3, 2'd3, 2'd0, 2'd3, 2'd3, 32'h7FFF7FFF, 32'h7FFF7FFF, 32'h40000000, 32'h7FFFFFFF, 4'd3},  // R3 hold
    '{3'd0, 2'd2, 2'd2, 2'd0, 2'd3, 2'd3, 32'h40002000, 32'h40004000, 32'h30000000, 32'h60000000, 4'd2},  // R2 sub
    '{3'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h80008000, 32'h80008000, 32'h7FFFFFFF, 32'h7FFFFFFF, 4'd4},  // R4 min*min
    '{3'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h7FFF8000, 32'h7FFF4000, 32'hC0000000, 32'h7FFE0002, 4'd4},  // R4
    '{3'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h7FFF8000, 32'h7FFF4000, 32'h80000000, 32'h7FFFFFFF, 4'd10}, // R10
    '{3'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd3, 32'h7FFF8000, 32'h7FFF4000, 32'h80000000, 32'h7FFE0002, 4'd10}, // R10 min
    '{3'd1, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd5},  // R5 clip
    '{3'd1, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h00018000, 32'h00038000, 32'h80000000, 32'h00000006, 4'd5},  // R5
    '{3'd2, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'hFFFF0003, 32'h00050007, 32'h00000015, 32'hFFFFFFFB, 4'd6},  // R6
    '{3'd2, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h80008000, 32'h80008000, 32'h40000015, 32'h3FFFFFFB, 4'd6},  // R6
    '{3'd3, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000002, 32'hFFFE0002, 4'd7},  // R7
    '{3'd3, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h80008000, 32'h80008000, 32'h7FFFFFFF, 32'h80000000, 4'd7},  // R7
    '{3'd4, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h20002000, 32'h20004000, 32'h20000000, 32'h10000000, 4'd8},  // R8
    '{3'd4, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h40004000, 32'h40004000, 32'h60000000, 32'h50000000, 4'd8},  // R8
    '{3'd4, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h40004000, 32'h40004000, 32'h7FFFFFFF, 32'h7FFFFFFF, 4'd8},  // R8 sat
    '{3'd5, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h0003FFFD, 32'h00040005, 32'hFFFFFFE2, 32'h00000018, 4'd9},  // R9
    '{3'd7, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h00004000, 32'h00004000, 32'h20000000, 32'h00000000, 4'd4},  // R4 code 7
    '{3'd0, 2'd0, 2'd0, 2'd2, 2'd1, 2'd3, 32'h20001000, 32'h08004000, 32'h10000000, 32'h01000000, 4'd11}, // R11
    '{3'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2, 32'h40002000, 32'h40004000, 32'h00000000, 32'h21000000, 4'd12}, // R12
    '{3'd0, 2'd3, 2'd3, 2'd0, 2'd3, 2'd3, 32'h00000000, 32'h00000000, 32'h20000000, 32'h21000000, 4'd12}  // R12
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] md, input logic [1:0] o0, input logic [1:0] o1,
                       input logic [1:0] s0, input logic [1:0] s1, input logic [1:0] w,
                       input logic [31:0] a, input logic [31:0] b);
    in_valid = 1'b1; fmt = md; op0 = o0; op1 = o1; sel0 = s0; sel1 = s1;
    wr0 = w[0]; wr1 = w[1]; src_a = a; src_b = b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    drive(3'd0, 2'd3, 2'd3, 2'd0, 2'd3, 2'd3, 32'h12345678, 32'h9ABCDEF0);
    @(negedge clk);
    chk("R1 acc0", res0, 32'd0);
    chk("R1 acc1", res1, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].md, VECS[i].o0, VECS[i].o1, VECS[i].s0, VECS[i].s1, VECS[i].wr,
            VECS[i].a, VECS[i].b);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d lane0", VECS[i].rq, i), res0, VECS[i].e0);
      chk($sformatf("R%0d vec%0d lane1", VECS[i].rq, i), res1, VECS[i].e1);
      if (VECS[i].rq == 4'd12) chk("R12 res_wr", {30'd0, res_wr}, {30'd0, VECS[i].wr});
    end

    // R2 wrap: 256 then 257 terms of 0x7FFFFFFF
    drive(3'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h80008000, 32'h80008000);
    @(negedge clk);
    for (int k = 0; k < 255; k++) begin
      drive(3'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h80008000, 32'h80008000);
      @(negedge clk);
    end
    chk("R2 below wrap", res0, 32'h7FFFFFFF);
    @(negedge clk);
    chk("R2 wrapped lane0", res0, 32'h80000000);
    chk("R2 wrapped lane1", res1, 32'h80000000);

    // R13 back-pressure
    in_valid = 1'b0;
    @(negedge clk);
    chk("R13 drained", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
    drive(3'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h40004000, 32'h40004000);
    @(negedge clk);
    chk("R13 first", res0, 32'h20000000);
    drive(3'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 32'h40004000, 32'h40004000);
    repeat (3) @(negedge clk);
    chk("R13 in_ready low", {31'd0, in_ready}, 32'd0);
    chk("R13 held res0", res0, 32'h20000000);
    chk("R13 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R13 one add lane0", res0, 32'h40000000);
    chk("R13 one add lane1", res1, 32'h40000000);
    @(negedge clk);
    chk("R13 valid drops", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule